// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and its read side run on two unrelated clocks. Words enter through a valid/ready stream port clocked by `wclk`. They leave through a valid/ready stream port clocked by `rclk`, in first-word fall-through form: the oldest stored word is already on `rd_data` whenever `rd_valid` is high.

Each side reports how full the buffer looks from its own clock domain.

- `af_n` is the almost-full warning. It is active low and registered on `wclk`.
- `ae_n` is the almost-empty warning. It is active low and registered on `rclk`.

Each flag has a threshold held in two 9-bit offset parts. The parts are written over the write data bus while `wr_load` is high.

Back-pressure works as follows. A word moves on a `wclk` edge where `wr_valid` and `wr_ready` are both high. The source holds `wr_data` stable until that happens. A word leaves on an `rclk` edge where `rd_valid` and `rd_ready` are both high. `wr_ready` drops only when the write side sees the buffer full and `wr_load` is low. Each side's count lags the other side's pointer by the synchronizer delay, so `wr_ready` and `rd_valid` err on the safe side.

Top module: `pf_async_fifo`

## Requirements
- R1: Every word accepted on the write port appears on `rd_data` unchanged and in acceptance order. `rd_data` presents the oldest word whenever `rd_valid` is high.
- R2: `wr_ready` is low only when `wr_load` is low and the write side counts `DEPTH` stored words. A write offered while `wr_ready` is low is dropped. The buffer accepts exactly `DEPTH` words before refusing.
- R3: `rd_valid` is low when the read side counts no stored words. A read request while `rd_valid` is low is ignored and moves no pointer.
- R4: Each `wclk` edge with `wr_load` and `wr_valid` both high stores `wr_data` into the next offset part. The parts are taken in the order: empty-threshold low, empty-threshold high, full-threshold low, full-threshold high. After the fourth part the order wraps to the first. The offset value is high*512 + low, clamped to `DEPTH`-1. No word is pushed while `wr_load` is high.
- R5: `af_n` is low exactly when the write-side count is at least `DEPTH` - m, where m is the full-threshold offset. It is registered such that the write that reaches the threshold is reflected right after its own edge.
- R6: A read that lowers the count is reflected in `af_n` and `wr_ready` within four `wclk` edges. The pointer crosses domains as a Gray code that changes at most one bit per cycle.
- R7: `ae_n` is low exactly when the read-side count is at most n, where n is the empty-threshold offset. A read is reflected right after its own `rclk` edge. A write is reflected within four `rclk` edges.
- R8: While `rst_n` is low the buffer becomes empty and the outputs read `af_n`=1, `ae_n`=0, `rd_valid`=0, `wr_ready`=1. Both offsets return to `AE_DEFAULT` and `AF_DEFAULT`, and the load order restarts at the empty-threshold low part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, both domains |
| wr_valid | input | 1 | Write word (or offset part) offered |
| wr_ready | output | 1 | Write side can take the offered word |
| wr_data | input | 9 | Write data, also offset part during loading |
| wr_load | input | 1 | High: bus writes go to the offset parts |
| rd_valid | output | 1 | A stored word is on `rd_data` |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_data | output | 9 | Oldest stored word |
| af_n | output | 1 | Almost-full flag, active low, `wclk` domain |
| ae_n | output | 1 | Almost-empty flag, active low, `rclk` domain |

## Verification
A push on a `wclk` edge and a pop on a nearby `rclk` edge can land together, and both change the count that `af_n` and `ae_n` judge. The bench provokes this by streaming both ports at once with pseudo-random valid and ready patterns, using clock periods that drift against each other. Every popped word is compared against a queue model, so order and content are judged exactly in all cases. A flag is compared against the model count only once the opposite domain has been quiet for long enough for its pointer to cross. Directed crossings then pin the threshold edges exactly.

// File: rtl/pf_async_fifo_pkg.sv
package pf_async_fifo_pkg;
  localparam int DATA_W = 9;
  localparam int PART_W = 9;

  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pf_ram.sv
module pf_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pf_ofs_regs.sv
module pf_ofs_regs
  import pf_async_fifo_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int OFS_W      = 8,
  parameter int AE_DEFAULT = 7,
  parameter int AF_DEFAULT = 7
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [PART_W-1:0] din,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);
  localparam int CAT_W = 2 * PART_W;
  localparam logic [CAT_W-1:0] AE_INIT = CAT_W'(AE_DEFAULT);
  localparam logic [CAT_W-1:0] AF_INIT = CAT_W'(AF_DEFAULT);
  localparam logic [2*CAT_W-1:0] INIT_ALL = {AF_INIT, AE_INIT};
  localparam logic [CAT_W-1:0] LIMIT = CAT_W'(DEPTH - 1);

  ofs_sel_e sel;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)        sel <= SEL_AE_LO;
    else if (load_stb) sel <= ofs_sel_e'(sel + 2'd1);
  end

  for (genvar k = 0; k < 4; k++) begin : g_part
    logic [PART_W-1:0] q;
    always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n)
        q <= INIT_ALL[k*PART_W +: PART_W];
      else if (load_stb && (sel == ofs_sel_e'(2'(k))))
        q <= din;
    end
  end

  logic [CAT_W-1:0] ae_cat, af_cat;

  always_comb begin
    ae_cat = {g_part[1].q, g_part[0].q};
    af_cat = {g_part[3].q, g_part[2].q};
    ae_ofs = (ae_cat > LIMIT) ? LIMIT[OFS_W-1:0] : ae_cat[OFS_W-1:0];
    af_ofs = (af_cat > LIMIT) ? LIMIT[OFS_W-1:0] : af_cat[OFS_W-1:0];
  end
endmodule

// File: rtl/pf_wr_ctrl.sv
module pf_wr_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_ofs,
  output logic          full,
  output logic          push,
  output logic [AW:0]   w_bin,
  output logic [AW:0]   w_gray,
  output logic          af_n
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [AW:0] r_bin_s, cnt, cnt_nxt, thresh, w_bin_nxt;

  always_comb begin
    r_bin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) r_bin_s[i] = r_bin_s[i+1] ^ rgray_s[i];
  end

  always_comb begin
    cnt       = w_bin - r_bin_s;
    full      = (cnt == DEPTH_V);
    push      = push_req && !full;
    w_bin_nxt = w_bin + (AW+1)'(push);
    cnt_nxt   = w_bin_nxt - r_bin_s;
    thresh    = DEPTH_V - {1'b0, af_ofs};
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      w_bin  <= '0;
      w_gray <= '0;
      af_n   <= 1'b1;
    end else begin
      w_bin  <= w_bin_nxt;
      w_gray <= w_bin_nxt ^ (w_bin_nxt >> 1);
      af_n   <= !(cnt_nxt >= thresh);
    end
  end
endmodule

// File: rtl/pf_rd_ctrl.sv
module pf_rd_ctrl #(
  parameter int AW = 8
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_ofs,
  output logic          empty,
  output logic          pop,
  output logic [AW:0]   r_bin,
  output logic [AW:0]   r_gray,
  output logic          ae_n
);
  logic [AW:0] w_bin_s, cnt, cnt_nxt, r_bin_nxt;

  always_comb begin
    w_bin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) w_bin_s[i] = w_bin_s[i+1] ^ wgray_s[i];
  end

  always_comb begin
    cnt       = w_bin_s - r_bin;
    empty     = (cnt == '0);
    pop       = pop_req && !empty;
    r_bin_nxt = r_bin + (AW+1)'(pop);
    cnt_nxt   = w_bin_s - r_bin_nxt;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      r_bin  <= '0;
      r_gray <= '0;
      ae_n   <= 1'b0;
    end else begin
      r_bin  <= r_bin_nxt;
      r_gray <= r_bin_nxt ^ (r_bin_nxt >> 1);
      ae_n   <= !(cnt_nxt <= {1'b0, ae_ofs});
    end
  end
endmodule

// File: rtl/pf_async_fifo.sv
module pf_async_fifo
  import pf_async_fifo_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int AE_DEFAULT  = 7,
  parameter int AF_DEFAULT  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_load,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              af_n,
  output logic              ae_n
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]   w_bin, w_gray, r_bin, r_gray, rgray_s, wgray_s;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic          full, push, empty, pop, load_stb;

  assign load_stb = wr_valid && wr_load;

  pf_ofs_regs #(
    .DEPTH(DEPTH), .OFS_W(AW), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)
  ) u_ofs (
    .wclk(wclk), .rst_n(rst_n), .load_stb(load_stb), .din(wr_data),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  pf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .push_req(wr_valid && !wr_load),
    .rgray_s(rgray_s), .af_ofs(af_ofs), .full(full), .push(push),
    .w_bin(w_bin), .w_gray(w_gray), .af_n(af_n)
  );

  pf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(r_gray), .q(rgray_s)
  );

  pf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(w_gray), .q(wgray_s)
  );

  pf_rd_ctrl #(.AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .pop_req(rd_ready), .wgray_s(wgray_s),
    .ae_ofs(ae_ofs), .empty(empty), .pop(pop), .r_bin(r_bin),
    .r_gray(r_gray), .ae_n(ae_n)
  );

  pf_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .wclk(wclk), .we(push), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .raddr(r_bin[AW-1:0]), .rdata(rd_data)
  );

  assign wr_ready = wr_load || !full;
  assign rd_valid = !empty;
endmodule

// File: rtl/pf_async_fifo_chk.sv
module pf_async_fifo_chk #(
  parameter int AW = 8
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        wr_load,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic        af_n,
  input logic        ae_n,
  input logic [AW:0] w_bin,
  input logic [AW:0] w_gray,
  input logic [AW:0] r_bin,
  input logic [AW:0] r_gray
);
  // R4: a load cycle never advances the write pointer
  assert_load_no_push_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_valid && wr_load) |=> (w_bin == $past(w_bin)));

  // R2: refused writes leave the write pointer alone
  assert_no_push_full_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_ready) |=> (w_bin == $past(w_bin)));

  // R3: reads with nothing presented leave the read pointer alone
  assert_no_pop_empty_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_valid && rd_ready) |=> (r_bin == $past(r_bin)));

  // R6: crossing pointers step by at most one bit
  assert_wgray_step_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    rst_n |=> ($countones(w_gray ^ $past(w_gray)) <= 1));

  assert_rgray_step_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    rst_n |=> ($countones(r_gray ^ $past(r_gray)) <= 1));

  // R5: a full buffer always shows the almost-full warning
  assert_full_implies_af_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_ready) |-> !af_n);

  // R7: an empty buffer always shows the almost-empty warning
  assert_empty_implies_ae_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_valid) |-> !ae_n);
endmodule

bind pf_async_fifo pf_async_fifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_load(wr_load), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .af_n(af_n), .ae_n(ae_n), .w_bin(w_bin),
  .w_gray(w_gray), .r_bin(r_bin), .r_gray(r_gray)
);

// File: tb/sim_pf_async_fifo.sv
module sim_pf_async_fifo;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH  = 64;
  localparam int AE_DEF = 4;
  localparam int AF_DEF = 4;
  localparam int QUIET  = 6;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_load = 1'b0, rd_ready = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_ready, rd_valid, af_n, ae_n;
  logic [8:0] rd_data;

  pf_async_fifo #(.DEPTH(DEPTH), .AE_DEFAULT(AE_DEF), .AF_DEFAULT(AF_DEF)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_load(wr_load),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .af_n(af_n), .ae_n(ae_n)
  );

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  int checks = 0, fails = 0;
  int wquiet = 0, rquiet = 0, seq = 0;
  int ae_lo = AE_DEF, ae_hi = 0, af_lo = AF_DEF, af_hi = 0;
  int exp_ae = AE_DEF, exp_af = AF_DEF;
  logic [8:0] q[$];
  logic [8:0] wdata_ctr = 9'd1;
  logic [15:0] wlfsr = 16'hACE1, rlfsr = 16'h1D35;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampv(int v);
    return (v > DEPTH - 1) ? DEPTH - 1 : v;
  endfunction

  // write-domain model and per-cycle comparison
  always @(negedge wclk) begin
    if (!rst_n) begin
      q.delete(); wquiet = 0; seq = 0;
      ae_lo = AE_DEF; ae_hi = 0; af_lo = AF_DEF; af_hi = 0;
      exp_ae = AE_DEF; exp_af = AF_DEF;
    end else begin
      if (wquiet < 1000) wquiet++;
      if (wquiet >= QUIET) begin
        chk("R5/R6 af_n vs model count", int'(af_n),
            (q.size() >= DEPTH - exp_af) ? 0 : 1);
        chk("R2 wr_ready vs model count", int'(wr_ready),
            (wr_load || q.size() < DEPTH) ? 1 : 0);
      end
      if (wr_valid && wr_load) begin
        case (seq)
          0: ae_lo = int'(wr_data);
          1: ae_hi = int'(wr_data);
          2: af_lo = int'(wr_data);
          default: af_hi = int'(wr_data);
        endcase
        seq = (seq + 1) % 4;
        exp_ae = clampv(ae_hi * 512 + ae_lo);
        exp_af = clampv(af_hi * 512 + af_lo);
        wquiet = 0; rquiet = 0;
      end else if (wr_valid && wr_ready) begin
        chk("R2 accepted word has room", (q.size() < DEPTH) ? 1 : 0, 1);
        q.push_back(wr_data);
        wdata_ctr = wdata_ctr + 9'd1;
        rquiet = 0;
      end
    end
  end

  // read-domain model and per-cycle comparison
  always @(negedge rclk) begin
    if (!rst_n) begin
      rquiet = 0;
    end else begin
      if (rquiet < 1000) rquiet++;
      if (rquiet >= QUIET) begin
        chk("R7 ae_n vs model count", int'(ae_n), (q.size() <= exp_ae) ? 0 : 1);
        chk("R3 rd_valid vs model count", int'(rd_valid), (q.size() > 0) ? 1 : 0);
      end
      if (rd_valid && rd_ready) begin
        chk("R3 presented word exists", (q.size() > 0) ? 1 : 0, 1);
        if (q.size() > 0) begin
          chk("R1 word order and content", int'(rd_data), int'(q[0]));
          void'(q.pop_front());
        end
        wquiet = 0;
      end
    end
  end

  task automatic wr_run(int n, bit rnd);
    repeat (n) begin
      @(posedge wclk); #1;
      wlfsr = {wlfsr[14:0], wlfsr[15] ^ wlfsr[13] ^ wlfsr[12] ^ wlfsr[10]};
      wr_valid = rnd ? wlfsr[0] : 1'b1;
      wr_data  = wdata_ctr;
    end
    @(posedge wclk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd_run(int n, bit rnd);
    repeat (n) begin
      @(posedge rclk); #1;
      rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
      rd_ready = rnd ? rlfsr[0] : 1'b1;
    end
    @(posedge rclk); #1;
    rd_ready = 1'b0;
  endtask

  task automatic load_part(logic [8:0] v);
    @(posedge wclk); #1;
    wr_load = 1'b1; wr_valid = 1'b1; wr_data = v;
  endtask

  task automatic load_end();
    @(posedge wclk); #1;
    wr_load = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic idle();
    repeat (12) @(posedge rclk);
    @(negedge wclk); #1;
  endtask

  task automatic do_reset();
    @(posedge wclk); #1;
    rst_n = 1'b0;
    repeat (4) @(posedge wclk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge wclk);
    @(negedge wclk); #1;
    chk("R8 af_n after reset", int'(af_n), 1);
    chk("R8 ae_n after reset", int'(ae_n), 0);
    chk("R8 rd_valid after reset", int'(rd_valid), 0);
    chk("R8 wr_ready after reset", int'(wr_ready), 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(WCLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // fill beyond capacity: extra words are refused
    wr_run(DEPTH + 6, 1'b0);
    idle();
    chk("R2 full refuses writes", int'(wr_ready), 0);
    chk("R2 capacity", q.size(), DEPTH);
    // drain beyond empty: extra reads ignored
    rd_run(DEPTH + 8, 1'b0);
    idle();
    chk("R3 empty after drain", int'(rd_valid), 0);
    // load: ae lo, ae hi, af lo, af hi, then wrap to ae lo
    load_part(9'd10); load_part(9'd0); load_part(9'd20); load_part(9'd0);
    load_part(9'd12); load_end();
    idle();
    chk("R4 no word pushed by loading", int'(rd_valid), 0);
    wr_run(12, 1'b0); idle();
    chk("R4 wrapped ae offset 12 at count 12", int'(ae_n), 0);
    wr_run(1, 1'b0); idle();
    chk("R7 ae_n high above offset", int'(ae_n), 1);
    wr_run(30, 1'b0); idle();
    chk("R5 af_n high at count 43", int'(af_n), 1);
    wr_run(1, 1'b0); idle();
    chk("R5 af_n low at count 44", int'(af_n), 0);
    rd_run(1, 1'b0); idle();
    chk("R6 af_n released after read", int'(af_n), 1);
    // concurrent traffic on both clocks
    fork
      wr_run(400, 1'b1);
      rd_run(300, 1'b1);
    join
    idle();
    rd_run(DEPTH + 4, 1'b0); idle();
    chk("R1 drained after traffic", q.size(), 0);
    // order now at ae hi: ae hi, af lo, af hi (clamps), ae lo
    load_part(9'd0); load_part(9'd0); load_part(9'd1); load_part(9'd12);
    load_end(); idle();
    wr_run(1, 1'b0); idle();
    chk("R4 af offset clamped to DEPTH-1", int'(af_n), 0);
    wr_run(19, 1'b0); idle();
    do_reset();
    chk("R8 buffer emptied by reset", int'(rd_valid), 0);
    wr_run(4, 1'b0); idle();
    chk("R8 default ae offset at count 4", int'(ae_n), 0);
    wr_run(1, 1'b0); idle();
    chk("R8 default ae offset at count 5", int'(ae_n), 1);
    chk("R8 default af offset at count 5", int'(af_n), 1);
    rd_run(8, 1'b0); idle();
    finish_run();
  end
endmodule